// File: doc/BRIEF.md
# I2C Serial EEPROM Read Target

This block is the read side of a 512-byte serial EEPROM that sits on a two-wire I2C bus as a target. It runs entirely in the system clock domain. The bus clock and data lines come in raw, pass through synchronisers, and are watched for edges, START and STOP. The block answers only to a device byte whose upper nibble is the fixed code 1010 and whose next two bits equal the strap inputs. Its single output is an open-drain pull-down enable for the data line.

A write transaction with a one-byte word address loads the internal address pointer. Bit 1 of the device byte supplies the ninth address bit, so the whole 512-byte space can be reached. A repeated START followed by a read device byte then streams bytes out of the array, most significant bit first. A read device byte sent without a preceding word address streams from wherever the pointer was left. The pointer advances after every byte that is fully sent and wraps from 511 to 0. The master ends a read with a HIGH acknowledge followed by STOP. Data bytes written by the master are neither stored nor acknowledged.

The array is filled through a synchronous preload port that bypasses the bus.

Top module: `eeprom_rd_target`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0) and the pointer is 0, so a current read issued first returns the byte at address 0.
- R2: The device byte is taken MSB first. The target acknowledges it, by pulling SDA low during the ninth clock, exactly when bits 7:4 are 1010 and bits 3:2 equal `strap_i[1:0]`. Bit 1 is the page bit and is not compared. Bit 0 selects a read when 1.
- R3: After a device byte that does not match, the target leaves SDA released, including on the acknowledge clocks of later bytes, until the next START.
- R4: Random read: START, device byte with bit 0 = 0 and page bit p, word address w, repeated START, device byte with bit 0 = 1. The target returns the byte at address {p, w}, MSB first.
- R5: A current read (device byte with bit 0 = 1 right after START) returns the byte at the last fully sent address plus one.
- R6: While the master acknowledges LOW after each byte, the target sends the byte at the next address. The address wraps from 511 to 0.
- R7: After a HIGH acknowledge the target releases SDA and drives nothing on further clocks until a START.
- R8: A START or STOP in the middle of a byte abandons the transfer. A START returns the target to device-byte reception. The pointer keeps the value set by the last fully completed access.
- R9: The target changes its SDA drive only while SCL is low.
- R10: A cycle with `pre_we_i` = 1 writes `pre_data_i` into address `pre_addr_i`, and later reads return that value.
- R11: A write transaction loads only the pointer. A data byte after the word address is not acknowledged and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired value) |
| strap_i | input | 2 | Device-select straps compared with device byte bits 3:2 |
| pre_we_i | input | 1 | Preload write enable |
| pre_addr_i | input | 9 | Preload address |
| pre_data_i | input | 8 | Preload data |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with its default two-stage synchronisers, the device code 1010, and the straps tied to 2'b10. This allows an exhaustive sweep over all 256 device bytes, which checks the acknowledge decision, the ignored page bit and the silence after a mismatch. It also allows one unbroken sequential read of all 512 addresses, starting at 1 and ending on the wrap to 0. Random reads hit both page edges and a stride across the array. Directed sequences cover aborts, the silence after a HIGH acknowledge, and the write transaction that moves only the pointer.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned WORD_ADDR_W = BYTE_W + 1;
  localparam int unsigned WORD_COUNT  = 1 << WORD_ADDR_W;
  localparam int unsigned BITCNT_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic                   scl_dly_q, sda_dly_q;

  // shift chain, next-state side
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb begin
        scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      end
    end else begin : g_single
      always_comb begin
        scl_pipe_d = scl_i;
        sda_pipe_d = sda_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_dly_q  <= 1'b1;
      sda_dly_q  <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_dly_q  <= scl_pipe_q[LAST];
      sda_dly_q  <= sda_pipe_q[LAST];
    end
  end

  assign scl_lvl_o  = scl_pipe_q[LAST];
  assign sda_lvl_o  = sda_pipe_q[LAST];
  assign scl_rise_o = scl_lvl_o & ~scl_dly_q;
  assign scl_fall_o = ~scl_lvl_o & scl_dly_q;
  // data edges while the clock stays high mark bus conditions
  assign start_o    = scl_lvl_o & scl_dly_q & sda_dly_q & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_dly_q & ~sda_dly_q & sda_lvl_o;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells_q [DEPTH];

  // R10: backdoor fill, storage carries no reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      cells_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = cells_q[rd_addr_i];
endmodule

// File: rtl/eeprom_rd_engine.sv
module eeprom_rd_engine
  import eeprom_rd_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_lvl_i,
  input  logic                   sda_lvl_i,
  input  logic                   scl_rise_i,
  input  logic                   scl_fall_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [1:0]             strap_i,
  input  logic [BYTE_W-1:0]      rd_data_i,
  output logic [WORD_ADDR_W-1:0] rd_addr_o,
  output logic                   sda_oe_o
);
  localparam logic [WORD_ADDR_W-1:0] PTR_ONE  = {{(WORD_ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [BITCNT_W-1:0]    CNT_FULL = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0]    CNT_ONE  = {{(BITCNT_W-1){1'b0}}, 1'b1};

  tgt_state_e               state_q, state_d;
  logic [BITCNT_W-1:0]      cnt_q, cnt_d;
  logic [BYTE_W-1:0]        shr_q, shr_d;
  logic [BYTE_W-1:0]        tx_q, tx_d;
  logic [WORD_ADDR_W-1:0]   ptr_q, ptr_d;
  logic                     page_q, page_d;
  logic                     rw_q, rw_d;
  logic                     mack_q, mack_d;
  logic                     oe_q, oe_d;
  logic                     addr_hit;

  // R2: code and straps compared, page bit (1) left out
  assign addr_hit = (shr_q[7:4] == DEV_CODE) && (shr_q[3:2] == strap_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shr_d   = shr_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    page_d  = page_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    if (start_i) begin
      // R8: any START restarts device-byte reception
      state_d = ST_DEVADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEVADDR, ST_WADDR: begin
          if (scl_rise_i && (cnt_q < CNT_FULL)) begin
            shr_d = {shr_q[BYTE_W-2:0], sda_lvl_i};
            cnt_d = cnt_q + CNT_ONE;
          end else if (scl_fall_i && (cnt_q == CNT_FULL)) begin
            cnt_d = '0;
            if (state_q == ST_DEVADDR) begin
              if (addr_hit) begin
                oe_d    = 1'b1;
                rw_d    = shr_q[0];
                page_d  = shr_q[1];
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_IGNORE;   // R3
              end
            end else begin
              ptr_d   = {page_q, shr_q};   // R4
              oe_d    = 1'b1;
              state_d = ST_WA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              tx_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              cnt_d   = CNT_ONE;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WADDR;
            end
          end
        end
        ST_WA_ACK: begin
          if (scl_fall_i) begin
            oe_d    = 1'b0;
            state_d = ST_IGNORE;   // R11: data bytes are not taken
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_FULL) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + PTR_ONE;   // R5 R6: byte fully sent
              cnt_d   = '0;
              state_d = ST_TX_ACK;
            end else begin
              oe_d  = ~tx_q[BYTE_W-2];
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + CNT_ONE;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            mack_d = sda_lvl_i;
          end else if (scl_fall_i) begin
            if (!mack_q) begin
              tx_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              cnt_d   = CNT_ONE;
              state_d = ST_TX;
            end else begin
              state_d = ST_IGNORE;   // R7
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;   // R1
      page_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shr_q   <= shr_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      page_q  <= page_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = oe_q;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(oe_q) |-> !scl_lvl_i); // R9
  AST_QUIET_STATES: assert property (@(posedge clk_i) disable iff (!rst_ni) ((state_q == ST_IDLE) || (state_q == ST_IGNORE)) |-> !oe_q); // R3
  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |=> (state_q == ST_DEVADDR)); // R8
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(ptr_q) |-> (($past(state_q) == ST_WADDR) || (ptr_q == ($past(ptr_q) + PTR_ONE)))); // R6
endmodule

// File: rtl/eeprom_rd_target.sv
module eeprom_rd_target
  import eeprom_rd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [1:0]             strap_i,
  input  logic                   pre_we_i,
  input  logic [WORD_ADDR_W-1:0] pre_addr_i,
  input  logic [BYTE_W-1:0]      pre_data_i,
  output logic                   sda_oe_o
);
  logic [1:0]             rst_pipe_q;
  logic                   rst_n_s;
  logic                   scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic [WORD_ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0]      rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe_q[1];

  eeprom_bus_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  eeprom_store #(
    .ADDR_W(WORD_ADDR_W),
    .DATA_W(BYTE_W)
  ) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (pre_we_i),
    .wr_addr_i (pre_addr_i),
    .wr_data_i (pre_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  eeprom_rd_engine #(
    .DEV_CODE(DEV_CODE)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .scl_lvl_i  (scl_lvl),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .sda_oe_o   (sda_oe_o)
  );
endmodule

// File: tb/sim_eeprom_rd_target.sv
module sim_eeprom_rd_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 3;
  localparam int WATCHDOG   = 195000;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 2'b00};

  logic       clk, rst_n, scl, m_sda, sda_bus, pre_we, sda_oe;
  logic [8:0] pre_addr;
  logic [7:0] pre_data;
  logic [7:0] model [512];
  int n_chk, n_fail, r9_bad;
  logic oe_prev;

  assign sda_bus = m_sda & ~sda_oe;

  eeprom_rd_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(STRAP),
    .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data), .sda_oe_o(sda_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R9 monitor: drive changes seen while the bench holds SCL high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl) r9_bad++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack);
  endtask

  task automatic read_byte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(nack);
  endtask

  task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte({DEV_W[7:2], a[8], 1'b0}, ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(DEV_W | 8'h01, ack);
    read_byte(d, 1'b1);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(DEV_W | 8'h01, ack);
    read_byte(d, 1'b1);
    bus_stop();
  endtask

  initial begin
    tick(WATCHDOG);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic       ack, b;
    logic [7:0] d;
    n_chk = 0; n_fail = 0; r9_bad = 0;
    scl = 1'b1; m_sda = 1'b1; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    rst_n = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R1 released after reset", int'(sda_oe), 0);

    // R10: fill through the preload port
    for (int a = 0; a < 512; a++) begin
      model[a] = 8'((a * 37 + (a >> 3) + 90) & 255);
      pre_we = 1'b1; pre_addr = 9'(a); pre_data = model[a];
      tick(1);
    end
    pre_we = 1'b0; tick(2);

    // R1: first current read starts at address 0
    bus_start();
    send_byte(DEV_W | 8'h01, ack);
    chk("R2 ack of read byte", int'(ack), 0);
    read_byte(d, 1'b1);
    bus_stop();
    chk("R1 first current read", int'(d), int'(model[0]));

    // R2 R3: exhaustive device byte sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] bv = 8'(v);
      logic exp_hit = (bv[7:4] == 4'b1010) && (bv[3:2] == STRAP);
      bus_start();
      send_byte(bv, ack);
      chk("R2 address match", int'(!ack), int'(exp_hit));
      if (!exp_hit && bv[1:0] == 2'b00) begin
        send_byte(8'h00, ack);
        chk("R3 silent after mismatch", int'(ack), 1);
      end
      if (exp_hit && bv[0]) read_byte(d, 1'b1);
      bus_stop();
    end

    // R4: random reads over both pages and edges
    for (int k = 0; k < 20; k++) begin
      int a = (k < 7) ? ((k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 255 : (k == 3) ? 256 :
                         (k == 4) ? 257 : (k == 5) ? 510 : 511) : (k - 7) * 41;
      rand_read(9'(a), d);
      chk("R4 random read", int'(d), int'(model[a]));
    end

    // R5: current read follows the last sent byte
    rand_read(9'd300, d);
    cur_read(d);
    chk("R5 current after random", int'(d), int'(model[301]));
    cur_read(d);
    chk("R5 second current read", int'(d), int'(model[302]));
    rand_read(9'd511, d);
    cur_read(d);
    chk("R6 current wraps to 0", int'(d), int'(model[0]));

    // R6: full sequential sweep from 1 through the wrap to 0
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h01, ack);
    bus_start();
    send_byte(DEV_W | 8'h01, ack);
    for (int i = 0; i < 512; i++) begin
      read_byte(d, (i == 511));
      chk("R6 sequential byte", int'(d), int'(model[(1 + i) % 512]));
    end
    bus_stop();
    cur_read(d);
    chk("R6 pointer after wrap", int'(d), int'(model[1]));

    // R7: nothing driven after a HIGH acknowledge
    rand_read(9'd40, d);
    bus_start();
    send_byte(DEV_W | 8'h01, ack);
    read_byte(d, 1'b1);
    chk("R7 byte before nack", int'(d), int'(model[41]));
    for (int i = 0; i < 9; i++) begin
      bit_in(b);
      chk("R7 line stays released", int'(b), 1);
    end
    bus_stop();

    // R8: START mid word address, then STOP mid device byte
    rand_read(9'd100, d);
    bus_start();
    send_byte(DEV_W, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start();
    send_byte(DEV_W | 8'h01, ack);
    chk("R8 ack after abort start", int'(ack), 0);
    read_byte(d, 1'b1);
    bus_stop();
    chk("R8 pointer kept after start abort", int'(d), int'(model[101]));
    bus_start();
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    bus_stop();
    cur_read(d);
    chk("R8 pointer kept after stop abort", int'(d), int'(model[102]));

    // R11: write transaction moves only the pointer
    bus_start();
    send_byte(DEV_W | 8'h02, ack);
    chk("R11 write device byte ack", int'(ack), 0);
    send_byte(8'h20, ack);
    chk("R11 word address ack", int'(ack), 0);
    send_byte(8'h00, ack);
    chk("R11 data byte not acked", int'(ack), 1);
    bus_stop();
    cur_read(d);
    chk("R11 array unchanged", int'(d), int'(model[9'h120]));

    // R10: overwrite one cell through the preload port
    pre_we = 1'b1; pre_addr = 9'h0AB; pre_data = 8'hC3; tick(1);
    pre_we = 1'b0; model[9'h0AB] = 8'hC3; tick(2);
    rand_read(9'h0AB, d);
    chk("R10 preload overwrite", int'(d), 32'hC3);

    chk("R9 drive changed with SCL high", r9_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule